// File: doc/BRIEF.md
# Descriptor Ring Pointer Tracker

This block keeps track of where a DMA engine stands in two descriptor rings, one for transmit and one for receive. Software sets up each ring with a base byte address and an entry count through a small register interface. The tracker stores the ring position as absolute byte addresses of fixed-size descriptors, 8 bytes each. It keeps two such addresses per ring: a *current* pointer, which is the descriptor now handed to the engine, and a *next* pointer, which is the descriptor the engine will take on its following request.

When the DMA engine asks for a descriptor, the tracker first checks the next pointer against the ring's extent. If the pointer lies outside the ring, the tracker falls back to the ring base. It latches the checked address as the current pointer and presents it to the engine one cycle later. When the engine reports that the descriptor is finished, the next pointer moves one descriptor past the current one and wraps to the base at the ring end.

A device reset, or a reload command written by software, puts both pointers of both rings back at their ring bases. All four pointers can be read as registers. Software can also overwrite the next pointers.

Top module: `desc_ring_tracker`

## Requirements
- R1: A ring holds (size field + 1) descriptors of 8 bytes. Its end address is base + entries × 8, so the last usable descriptor starts at end − 8. A single-entry ring is valid.
- R2: On a fetch request, if the next pointer is below the ring base, the ring base is used as the current descriptor address instead.
- R3: On a fetch request, if the next pointer plus 8 is greater than the ring end, the ring base is used instead. A next pointer that fits exactly (next + 8 == end) is used unchanged.
- R4: A fetch request at one clock edge loads the checked address into the current pointer. At the following edge, `*_desc_valid` goes high for exactly one cycle and `*_desc_addr` carries that address. The current-pointer register reads the same value.
- R5: A done strobe sets the next pointer to the current pointer + 8. If that sum is equal to or greater than the ring end, the next pointer is set to the ring base instead.
- R6: A synchronous active-high `rst` clears the base and size registers. Both pointers of both rings read 0, and the valid outputs are low.
- R7: Writing control offset 0x10C with bit 0 set loads the current and next pointers of both rings with their ring bases at that edge. The command self-clears, and 0x10C reads 0. Writing a base register on its own moves no pointer.
- R8: A reload command takes priority over a fetch and a done in the same cycle. The done is dropped, and the fetch produces no valid pulse.
- R9: The transmit and receive rings move independently. A fetch or done on one ring leaves the other ring's pointers unchanged.
- R10: The register map is as follows: tx base 0x100, rx base 0x104, tx current 0x11C, rx current 0x120, tx next 0x134, rx next 0x138. Next pointers are writable. Writes to the current pointers are ignored. Unmapped offsets read 0. Read data is registered, which gives one cycle of latency.
- R11: The size register at 0x108 holds the tx size field in bits [SIZE_W-1:0] and the rx size field in bits [16+SIZE_W-1:16]. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 12 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_ofs | input | 12 | Register read byte offset |
| reg_rd_data | output | 32 | Registered read data, one cycle after the strobe |
| tx_fetch_req | input | 1 | Transmit engine requests a descriptor |
| tx_desc_done | input | 1 | Transmit engine finished the current descriptor |
| tx_desc_addr | output | ADDR_W | Current transmit descriptor address |
| tx_desc_valid | output | 1 | One-cycle pulse: tx_desc_addr answers a fetch |
| rx_fetch_req | input | 1 | Receive engine requests a descriptor |
| rx_desc_done | input | 1 | Receive engine finished the current descriptor |
| rx_desc_addr | output | ADDR_W | Current receive descriptor address |
| rx_desc_valid | output | 1 | One-cycle pulse: rx_desc_addr answers a fetch |

## Verification
The bench steps a four-entry transmit ring and a two-entry receive ring through their last entry and checks the wrap. A design that compared with greater-than instead of greater-or-equal would step one descriptor past the end. The bench corrupts the next pointer in three ways: below the base, exactly at the end, and straddling the end. It also sets a value that fits exactly. An off-by-one in the range check either accepts the straddling pointer or rejects the exact fit. The bench moves the base and then issues a reload, to catch a design that reloads from a stale base or moves pointers on the base write alone. It also drives a reload in the same cycle as a done and as a fetch, which exposes any design that lets the engine strobes win.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;
  localparam int REG_DW    = 32;
  localparam int OFS_W     = 12;
  localparam int NUM_RINGS = 2;
  localparam int RING_TX   = 0;
  localparam int RING_RX   = 1;

  // size register: rx field starts here (tx field starts at bit 0)
  localparam int RX_SIZE_LSB    = 16;
  // control register: pointer reload command bit
  localparam int CMD_RELOAD_BIT = 0;

  localparam logic [OFS_W-1:0] OFS_TX_BASE   = 12'h100;
  localparam logic [OFS_W-1:0] OFS_RX_BASE   = 12'h104;
  localparam logic [OFS_W-1:0] OFS_RING_SIZE = 12'h108;
  localparam logic [OFS_W-1:0] OFS_CTRL      = 12'h10C;
  localparam logic [OFS_W-1:0] OFS_TX_CUR    = 12'h11C;
  localparam logic [OFS_W-1:0] OFS_RX_CUR    = 12'h120;
  localparam logic [OFS_W-1:0] OFS_TX_NEXT   = 12'h134;
  localparam logic [OFS_W-1:0] OFS_RX_NEXT   = 12'h138;
endpackage

// File: rtl/ring_extent.sv
// Ring end address: base + (size field + 1) * descriptor bytes, one bit wider
// than the address so that a ring ending at the top of memory does not alias.
module ring_extent #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 10,
  parameter int DESC_BYTES = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] cnt_m1,
  output logic [ADDR_W:0]   end_addr
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] entries;
  logic [EW-1:0] span;

  always_comb begin
    entries  = EW'(cnt_m1) + EW'(1);               // R1
    span     = entries * EW'(DESC_BYTES);
    end_addr = {1'b0, base} + span;
  end
endmodule

// File: rtl/ring_ptr_unit.sv
// One ring's current/next pointer pair with range check and wrap.
module ring_ptr_unit #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   end_addr,
  input  logic              next_wr,
  input  logic [ADDR_W-1:0] next_wdata,
  input  logic              fetch,
  input  logic              done,
  output logic [ADDR_W-1:0] cur_q,
  output logic [ADDR_W-1:0] next_q,
  output logic              valid_q
);
  localparam int EW = ADDR_W + 1;
  localparam logic [EW-1:0] STEP = EW'(DESC_BYTES);

  logic [EW-1:0]     next_ext;
  logic [EW-1:0]     base_ext;
  logic              below_base;
  logic              past_end;
  logic [ADDR_W-1:0] checked;
  logic [EW-1:0]     stepped;
  logic [ADDR_W-1:0] advanced;

  always_comb begin
    next_ext   = {1'b0, next_q};
    base_ext   = {1'b0, base};
    below_base = next_ext < base_ext;              // R2
    past_end   = (next_ext + STEP) > end_addr;     // R3
    checked    = (below_base || past_end) ? base : next_q;
    stepped    = {1'b0, cur_q} + STEP;             // R5
    advanced   = (stepped >= end_addr) ? base : stepped[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      next_q  <= '0;
      valid_q <= 1'b0;
    end else if (reload) begin                     // R7 R8
      cur_q   <= base;
      next_q  <= base;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fetch;                            // R4
      if (fetch) cur_q <= checked;
      if (next_wr)   next_q <= next_wdata;         // R10
      else if (done) next_q <= advanced;
    end
  end
endmodule

// File: rtl/ring_regs.sv
// Software-visible registers: ring bases, size fields, reload command and
// pointer read-back, with a registered read port.
module ring_regs
  import ring_trk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 10
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [OFS_W-1:0]                    wr_ofs,
  input  logic [REG_DW-1:0]                   wr_data,
  input  logic                                rd_en,
  input  logic [OFS_W-1:0]                    rd_ofs,
  output logic [REG_DW-1:0]                   rd_data,
  input  logic [NUM_RINGS-1:0][ADDR_W-1:0]    cur_in,
  input  logic [NUM_RINGS-1:0][ADDR_W-1:0]    next_in,
  output logic [NUM_RINGS-1:0][ADDR_W-1:0]    base_q,
  output logic [NUM_RINGS-1:0][SIZE_W-1:0]    cnt_m1_q,
  output logic                                reload,
  output logic [NUM_RINGS-1:0]                next_wr,
  output logic [ADDR_W-1:0]                   next_wdata
);
  logic [REG_DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_m1_q <= '0;
    end else if (wr_en) begin
      case (wr_ofs)
        OFS_TX_BASE: base_q[RING_TX] <= wr_data[ADDR_W-1:0];
        OFS_RX_BASE: base_q[RING_RX] <= wr_data[ADDR_W-1:0];
        OFS_RING_SIZE: begin                                   // R11
          cnt_m1_q[RING_TX] <= wr_data[SIZE_W-1:0];
          cnt_m1_q[RING_RX] <= wr_data[RX_SIZE_LSB +: SIZE_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reload           = wr_en && (wr_ofs == OFS_CTRL) && wr_data[CMD_RELOAD_BIT];
    next_wr[RING_TX] = wr_en && (wr_ofs == OFS_TX_NEXT);
    next_wr[RING_RX] = wr_en && (wr_ofs == OFS_RX_NEXT);
    next_wdata       = wr_data[ADDR_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (rd_ofs)
      OFS_TX_BASE: rd_mux = REG_DW'(base_q[RING_TX]);
      OFS_RX_BASE: rd_mux = REG_DW'(base_q[RING_RX]);
      OFS_RING_SIZE: begin
        rd_mux[SIZE_W-1:0]             = cnt_m1_q[RING_TX];
        rd_mux[RX_SIZE_LSB +: SIZE_W]  = cnt_m1_q[RING_RX];
      end
      OFS_TX_CUR:  rd_mux = REG_DW'(cur_in[RING_TX]);
      OFS_RX_CUR:  rd_mux = REG_DW'(cur_in[RING_RX]);
      OFS_TX_NEXT: rd_mux = REG_DW'(next_in[RING_TX]);
      OFS_RX_NEXT: rd_mux = REG_DW'(next_in[RING_RX]);
      default:     rd_mux = '0;                                // R10
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import ring_trk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 10,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [11:0]       reg_wr_ofs,
  input  logic [31:0]       reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [11:0]       reg_rd_ofs,
  output logic [31:0]       reg_rd_data,
  input  logic              tx_fetch_req,
  input  logic              tx_desc_done,
  output logic [ADDR_W-1:0] tx_desc_addr,
  output logic              tx_desc_valid,
  input  logic              rx_fetch_req,
  input  logic              rx_desc_done,
  output logic [ADDR_W-1:0] rx_desc_addr,
  output logic              rx_desc_valid
);
  logic [NUM_RINGS-1:0][ADDR_W-1:0] base_q;
  logic [NUM_RINGS-1:0][SIZE_W-1:0] cnt_m1_q;
  logic [NUM_RINGS-1:0][ADDR_W:0]   ring_end;
  logic [NUM_RINGS-1:0][ADDR_W-1:0] cur_v;
  logic [NUM_RINGS-1:0][ADDR_W-1:0] next_v;
  logic [NUM_RINGS-1:0]             valid_v;
  logic [NUM_RINGS-1:0]             fetch_v;
  logic [NUM_RINGS-1:0]             done_v;
  logic [NUM_RINGS-1:0]             next_wr;
  logic [ADDR_W-1:0]                next_wdata;
  logic                             reload;

  always_comb begin
    fetch_v[RING_TX] = tx_fetch_req;
    fetch_v[RING_RX] = rx_fetch_req;
    done_v[RING_TX]  = tx_desc_done;
    done_v[RING_RX]  = rx_desc_done;
  end

  ring_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wr_ofs     (reg_wr_ofs),
    .wr_data    (reg_wr_data),
    .rd_en      (reg_rd_en),
    .rd_ofs     (reg_rd_ofs),
    .rd_data    (reg_rd_data),
    .cur_in     (cur_v),
    .next_in    (next_v),
    .base_q     (base_q),
    .cnt_m1_q   (cnt_m1_q),
    .reload     (reload),
    .next_wr    (next_wr),
    .next_wdata (next_wdata)
  );

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    ring_extent #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DESC_BYTES(DESC_BYTES)) u_ext (
      .base     (base_q[r]),
      .cnt_m1   (cnt_m1_q[r]),
      .end_addr (ring_end[r])
    );

    ring_ptr_unit #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
      .clk        (clk),
      .rst        (rst),
      .reload     (reload),
      .base       (base_q[r]),
      .end_addr   (ring_end[r]),
      .next_wr    (next_wr[r]),
      .next_wdata (next_wdata),
      .fetch      (fetch_v[r]),
      .done       (done_v[r]),
      .cur_q      (cur_v[r]),
      .next_q     (next_v[r]),
      .valid_q    (valid_v[r])
    );
  end

  always_comb begin
    tx_desc_addr  = cur_v[RING_TX];
    rx_desc_addr  = cur_v[RING_RX];
    tx_desc_valid = valid_v[RING_TX];
    rx_desc_valid = valid_v[RING_RX];
  end
endmodule

// File: rtl/ring_trk_checker.sv
module ring_trk_checker
  import ring_trk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 10,
  parameter int DESC_BYTES = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_RINGS-1:0][ADDR_W-1:0] base,
  input logic [NUM_RINGS-1:0][SIZE_W-1:0] cnt_m1,
  input logic                             reload,
  input logic [NUM_RINGS-1:0]             next_wr,
  input logic [NUM_RINGS-1:0]             fetch,
  input logic [NUM_RINGS-1:0]             done,
  input logic [NUM_RINGS-1:0]             desc_valid,
  input logic [NUM_RINGS-1:0][ADDR_W-1:0] cur,
  input logic [NUM_RINGS-1:0][ADDR_W-1:0] nxt
);
  localparam int EW = ADDR_W + 1;

  logic [NUM_RINGS-1:0][EW-1:0] lim;

  always_comb begin
    for (int r = 0; r < NUM_RINGS; r++)
      lim[r] = {1'b0, base[r]} + (EW'(cnt_m1[r]) + EW'(1)) * EW'(DESC_BYTES);
  end

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_chk
    AST_VALID_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
      desc_valid[r] |-> ($past(fetch[r]) && !$past(reload)));                        // R4
    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
      (desc_valid[r] && $stable(base[r]) && $stable(cnt_m1[r])) |->
        ({1'b0, cur[r]} >= {1'b0, base[r]} &&
         {1'b0, cur[r]} + EW'(DESC_BYTES) <= lim[r]));                               // R3
    AST_RELOAD_TO_BASE: assert property (@(posedge clk) disable iff (rst)
      reload |=> (cur[r] == $past(base[r]) && nxt[r] == $past(base[r])));            // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!fetch[r] && !done[r] && !reload && !next_wr[r]) |=>
        ($stable(cur[r]) && $stable(nxt[r])));                                       // R9
    AST_DONE_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (rst)
      (done[r] && !reload && !next_wr[r]) |=>
        (nxt[r] == $past(cur[r]) + ADDR_W'(DESC_BYTES) || nxt[r] == $past(base[r]))); // R5
  end
endmodule

bind desc_ring_tracker ring_trk_checker #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DESC_BYTES(DESC_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .base       (base_q),
  .cnt_m1     (cnt_m1_q),
  .reload     (reload),
  .next_wr    (next_wr),
  .fetch      (fetch_v),
  .done       (done_v),
  .desc_valid (valid_v),
  .cur        (cur_v),
  .nxt        (next_v)
);

// File: tb/tb_desc_ring_tracker.sv
module tb_desc_ring_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef enum logic [2:0] {
    OP_WR = 3'd0, OP_RD = 3'd1, OP_TXF = 3'd2, OP_RXF = 3'd3, OP_TXD = 3'd4, OP_RXD = 3'd5
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [11:0] ofs;
    logic [31:0] val;   // write data or expected value
    logic [3:0]  req;   // requirement number for messages
  } vec_t;

  localparam int NV = 54;
  localparam vec_t TV [NV] = '{
    '{OP_RD,  12'h11C, 32'h0000_0000, 4'd6},   // R6 tx current after reset
    '{OP_RD,  12'h138, 32'h0000_0000, 4'd6},   // R6 rx next after reset
    '{OP_WR,  12'h100, 32'h0000_1000, 4'd0},
    '{OP_WR,  12'h104, 32'h0000_2000, 4'd0},
    '{OP_WR,  12'h108, 32'h0001_0003, 4'd0},   // tx 4 entries, rx 2 entries
    '{OP_RD,  12'h108, 32'h0001_0003, 4'd11},  // R11 size fields read back
    '{OP_RD,  12'h134, 32'h0000_0000, 4'd7},   // R7 base write alone moves nothing
    '{OP_WR,  12'h10C, 32'h0000_0001, 4'd0},   // reload command
    '{OP_RD,  12'h11C, 32'h0000_1000, 4'd7},   // R7
    '{OP_RD,  12'h134, 32'h0000_1000, 4'd7},   // R7
    '{OP_RD,  12'h120, 32'h0000_2000, 4'd7},   // R7
    '{OP_TXF, 12'h000, 32'h0000_1000, 4'd4},   // R4
    '{OP_TXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_RD,  12'h134, 32'h0000_1008, 4'd5},   // R5 step
    '{OP_TXF, 12'h000, 32'h0000_1008, 4'd4},
    '{OP_TXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1010, 4'd4},
    '{OP_TXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1018, 4'd1},   // R1 last of four entries
    '{OP_TXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_RD,  12'h134, 32'h0000_1000, 4'd5},   // R5 wrap at last entry
    '{OP_RD,  12'h11C, 32'h0000_1018, 4'd4},   // R4 current readback
    '{OP_RXF, 12'h000, 32'h0000_2000, 4'd4},
    '{OP_RXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_RXF, 12'h000, 32'h0000_2008, 4'd1},   // R1 last of two entries
    '{OP_RXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_RD,  12'h138, 32'h0000_2000, 4'd5},   // R5 rx wrap
    '{OP_RD,  12'h134, 32'h0000_1000, 4'd9},   // R9 tx untouched by rx
    '{OP_WR,  12'h134, 32'h0000_0FF8, 4'd0},
    '{OP_RD,  12'h134, 32'h0000_0FF8, 4'd10},  // R10 next writable
    '{OP_TXF, 12'h000, 32'h0000_1000, 4'd2},   // R2 below base
    '{OP_WR,  12'h134, 32'h0000_1020, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1000, 4'd3},   // R3 at end
    '{OP_WR,  12'h134, 32'h0000_101C, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1000, 4'd3},   // R3 straddles end
    '{OP_WR,  12'h134, 32'h0000_1018, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1018, 4'd3},   // R3 exact fit kept
    '{OP_WR,  12'h11C, 32'hDEAD_0000, 4'd0},
    '{OP_RD,  12'h11C, 32'h0000_1018, 4'd10},  // R10 current not writable
    '{OP_RD,  12'h10C, 32'h0000_0000, 4'd7},   // R7 command reads 0
    '{OP_RD,  12'h1F0, 32'h0000_0000, 4'd10},  // R10 unmapped
    '{OP_RD,  12'h120, 32'h0000_2008, 4'd9},   // R9 rx untouched by tx
    '{OP_WR,  12'h108, 32'h0001_0000, 4'd0},   // tx single entry
    '{OP_WR,  12'h134, 32'h0000_1000, 4'd0},
    '{OP_TXF, 12'h000, 32'h0000_1000, 4'd1},   // R1
    '{OP_TXD, 12'h000, 32'h0000_0000, 4'd0},
    '{OP_RD,  12'h134, 32'h0000_1000, 4'd1},   // R1 single-entry wrap
    '{OP_WR,  12'h100, 32'h0000_3000, 4'd0},
    '{OP_RD,  12'h134, 32'h0000_1000, 4'd7},   // R7 base move alone
    '{OP_TXF, 12'h000, 32'h0000_3000, 4'd2},   // R2 stale next below new base
    '{OP_WR,  12'h10C, 32'h0000_0001, 4'd0},
    '{OP_RD,  12'h11C, 32'h0000_3000, 4'd7},   // R7 reload from new base
    '{OP_RD,  12'h138, 32'h0000_2000, 4'd7},   // R7
    '{OP_RD,  12'h120, 32'h0000_2000, 4'd7}    // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [11:0]   reg_wr_ofs = '0;
  logic [31:0]   reg_wr_data = '0;
  logic          reg_rd_en = 1'b0;
  logic [11:0]   reg_rd_ofs = '0;
  logic [31:0]   reg_rd_data;
  logic          tx_fetch_req = 1'b0;
  logic          tx_desc_done = 1'b0;
  logic [AW-1:0] tx_desc_addr;
  logic          tx_desc_valid;
  logic          rx_fetch_req = 1'b0;
  logic          rx_desc_done = 1'b0;
  logic [AW-1:0] rx_desc_addr;
  logic          rx_desc_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_tracker dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_ofs(reg_wr_ofs), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_ofs(reg_rd_ofs), .reg_rd_data(reg_rd_data),
    .tx_fetch_req(tx_fetch_req), .tx_desc_done(tx_desc_done),
    .tx_desc_addr(tx_desc_addr), .tx_desc_valid(tx_desc_valid),
    .rx_fetch_req(rx_fetch_req), .rx_desc_done(rx_desc_done),
    .rx_desc_addr(rx_desc_addr), .rx_desc_valid(rx_desc_valid)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_ofs = ofs; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] ofs, input logic [31:0] exp, input int req);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_ofs = ofs;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(req, $sformatf("read %03h", ofs), reg_rd_data, exp);
  endtask

  task automatic fetch(input bit rx, input logic [31:0] exp, input int req);
    @(negedge clk);
    if (rx) rx_fetch_req = 1'b1; else tx_fetch_req = 1'b1;
    @(negedge clk);
    rx_fetch_req = 1'b0; tx_fetch_req = 1'b0;
    if (rx) begin
      check(req, "rx valid", 32'(rx_desc_valid), 32'd1);
      check(req, "rx addr", rx_desc_addr, exp);
    end else begin
      check(req, "tx valid", 32'(tx_desc_valid), 32'd1);
      check(req, "tx addr", tx_desc_addr, exp);
    end
    @(negedge clk);
    check(4, "valid single pulse", 32'(rx ? rx_desc_valid : tx_desc_valid), 32'd0); // R4
  endtask

  task automatic done(input bit rx);
    @(negedge clk);
    if (rx) rx_desc_done = 1'b1; else tx_desc_done = 1'b1;
    @(negedge clk);
    rx_desc_done = 1'b0; tx_desc_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(6, "tx valid in reset", 32'(tx_desc_valid), 32'd0);  // R6

    for (int i = 0; i < NV; i++) begin
      case (TV[i].op)
        OP_WR:  reg_write(TV[i].ofs, TV[i].val);
        OP_RD:  reg_read(TV[i].ofs, TV[i].val, int'(TV[i].req));
        OP_TXF: fetch(1'b0, TV[i].val, int'(TV[i].req));
        OP_RXF: fetch(1'b1, TV[i].val, int'(TV[i].req));
        OP_TXD: done(1'b0);
        OP_RXD: done(1'b1);
        default: ;
      endcase
    end

    // R8: reload and done in the same cycle; done is dropped
    reg_write(12'h108, 32'h0001_0003);
    fetch(1'b0, 32'h0000_3000, 4);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_ofs = 12'h10C; reg_wr_data = 32'h1; tx_desc_done = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; tx_desc_done = 1'b0;
    reg_read(12'h134, 32'h0000_3000, 8);

    // R8: reload and fetch in the same cycle; no valid pulse, base wins
    reg_write(12'h134, 32'h0000_3010);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_ofs = 12'h10C; reg_wr_data = 32'h1; tx_fetch_req = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; tx_fetch_req = 1'b0;
    check(8, "tx valid after reload+fetch", 32'(tx_desc_valid), 32'd0);
    check(8, "tx addr after reload+fetch", tx_desc_addr, 32'h0000_3000);

    // R9: both rings fetch in the same cycle
    @(negedge clk);
    tx_fetch_req = 1'b1; rx_fetch_req = 1'b1;
    @(negedge clk);
    tx_fetch_req = 1'b0; rx_fetch_req = 1'b0;
    check(9, "tx addr joint fetch", tx_desc_addr, 32'h0000_3000);
    check(9, "rx addr joint fetch", rx_desc_addr, 32'h0000_2000);
    check(9, "rx valid joint fetch", 32'(rx_desc_valid), 32'd1);

    // R6: device reset clears bases, sizes and pointers
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reg_read(12'h100, 32'h0, 6);
    reg_read(12'h108, 32'h0, 6);
    reg_read(12'h11C, 32'h0, 6);
    reg_read(12'h138, 32'h0, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule